// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the series of column addresses a memory controller presents to an SDRAM-style array, one address per clock. A request carries a starting column and a 12-bit mode word. The low four bits of the mode word choose how many beats the burst has and the order in which the beats visit the columns. The block drives a column address with a valid flag and a last-beat flag. Bits 11:4 of the mode word have no effect.

Fixed-length bursts stay inside an aligned group of columns whose size equals the burst length. The low address bits move through that group in ascending order with wrap-around, or in exclusive-or order. The full-page mode walks the whole 1,024-column row in ascending order and wraps at the end of the row. It runs until the controller raises the terminate input, so the controller can build a burst of any length. A mode code that is not a legal combination raises a one-cycle error flag, and no burst is issued.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `col_valid`, `col_last` and `cfg_err` are 0 and `col_out` is 0.
- R2: When `start` is sampled high with a legal mode, the next cycle shows beat 0: `col_valid`=1 and `col_out` equal to the sampled `start_col`. Each later beat follows one cycle after the previous one.
- R3: Mode word bits 2:0 set the length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page. Bit 3 = 0 selects ascending order and bit 3 = 1 selects exclusive-or order. A fixed burst of length L issues exactly L beats, and `col_last`=1 only on the beat numbered L-1.
- R4: In ascending order, beat n of a length-L burst has its low log2(L) bits equal to (start + n) mod L. The bits above them are equal to those of `start_col`.
- R5: In exclusive-or order, beat n has its low log2(L) bits equal to (start low bits) XOR n. The upper bits are held as in R4.
- R6: In full-page mode, beat n is (start_col + n) mod 1024. Beats continue without limit. When `terminate` is sampled high at the edge that produces a beat, that beat carries `col_last`=1 and is the final beat. This includes the start edge itself.
- R7: The length codes 100, 101 and 110 are illegal, and so is code 111 with bit 3 = 1. A start with an illegal code raises `cfg_err` for exactly the next cycle and produces no beat.
- R8: A `start` during an active burst aborts it. The new burst's beat 0 appears in the next cycle with no gap. An illegal start during a burst also ends the burst.
- R9: `terminate` has no effect on fixed-length bursts. The beat values and the length are unchanged.
- R10: In the cycle after a last beat, `col_valid` is 0 unless `start` was sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the current start_col and mode_word |
| start_col | input | 10 | Starting column of the burst |
| mode_word | input | 12 | Bits 2:0 set the length code, bit 3 sets the order; bits 11:4 are ignored |
| terminate | input | 1 | Makes the next full-page beat the final one |
| col_out | output | 10 | Column address of the current beat |
| col_valid | output | 1 | col_out holds a beat of the burst |
| col_last | output | 1 | The current beat is the final one |
| cfg_err | output | 1 | One-cycle pulse after a start with an illegal mode |

## Verification
The hardest situations to reach are the edges of a full-page burst. One is the wrap from column 1023 back to 0 inside an open-ended burst. The other is a terminate that lands at the very edge where the burst starts. Directed bursts cover both: one starts at 0x3FE, one runs longer than a whole row, and one raises terminate together with start. An abort that lands in the middle of an eight-beat burst is forced directly. Random bursts then mix every length code, both orders, illegal codes and stray terminate pulses on fixed bursts.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       len_code,
  input  logic             ilv,
  output logic [COL_W-1:0] mask,
  output logic             full,
  output logic             bad
);
  always_comb begin
    mask = '0;
    full = 1'b0;
    bad  = 1'b0;
    case (len_code)
      BL_1:    mask = COL_W'(0);
      BL_2:    mask = COL_W'(1);
      BL_4:    mask = COL_W'(3);
      BL_8:    mask = COL_W'(7);
      BL_PAGE: begin
        mask = '1;
        full = 1'b1;
        bad  = ilv;
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] off_seq;
  logic [COL_W-1:0] off_ilv;
  logic [COL_W-1:0] off;

  assign off_seq = base + beat;
  assign off_ilv = base ^ beat;
  assign off     = ilv ? off_ilv : off_seq;

  for (genvar i = 0; i < COL_W; i++) begin : g_merge
    assign col[i] = mask[i] ? off[i] : base[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              terminate,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic              cfg_err
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full, dec_bad;
  logic [COL_W-1:0] base_q, beat_q, len_mask_q;
  logic             ilv_q, full_q;
  logic [COL_W-1:0] nx_base, nx_beat, nx_mask, nx_col;
  logic             nx_ilv, nx_full;
  logic             accept, advance;
  logic             unused_mode;

  assign unused_mode = ^mode_word[MODE_W-1:4];

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (mode_word[2:0]),
    .ilv      (mode_word[3]),
    .mask     (dec_mask),
    .full     (dec_full),
    .bad      (dec_bad)
  );

  assign accept  = start & ~dec_bad;
  assign advance = col_valid & ~col_last & ~start;

  assign nx_base = start ? start_col    : base_q;
  assign nx_beat = start ? '0           : beat_q + 1'b1;
  assign nx_mask = start ? dec_mask     : len_mask_q;
  assign nx_ilv  = start ? mode_word[3] : ilv_q;
  assign nx_full = start ? dec_full     : full_q;

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .base (nx_base),
    .beat (nx_beat),
    .mask (nx_mask),
    .ilv  (nx_ilv),
    .col  (nx_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      beat_q     <= '0;
      len_mask_q <= '0;
      ilv_q      <= 1'b0;
      full_q     <= 1'b0;
      col_out    <= '0;
      col_valid  <= 1'b0;
      col_last   <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      cfg_err <= start & dec_bad;
      if (accept | advance) begin
        base_q     <= nx_base;
        beat_q     <= nx_beat;
        len_mask_q <= nx_mask;
        ilv_q      <= nx_ilv;
        full_q     <= nx_full;
        col_out    <= nx_col;
        col_valid  <= 1'b1;
        col_last   <= nx_full ? terminate : (nx_beat == nx_mask);
      end else begin
        col_valid  <= 1'b0;
        col_last   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int COL_W  = 10,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic [MODE_W-1:0] mode_word,
  input logic [COL_W-1:0]  col_out,
  input logic              col_valid,
  input logic              col_last,
  input logic              cfg_err,
  input logic [COL_W-1:0]  mask_q,
  input logic              ilv_q
);
  logic code_bad;
  assign code_bad = (mode_word[2] & ~(mode_word[1] & mode_word[0]))
                  | (&mode_word[2:0] & mode_word[3]);

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid); // R3

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    start && !code_bad |=> col_valid && col_out == $past(start_col)); // R2

  AST_BLOCK_HELD: assert property (@(posedge clk) disable iff (rst)
    col_valid && !start && !col_last |=>
      (col_out & ~mask_q) == ($past(col_out) & ~mask_q)); // R4

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    col_valid && !start && !col_last && !ilv_q |=>
      (col_out & mask_q) == (($past(col_out) + 1'b1) & mask_q)); // R4

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    start && code_bad |=> cfg_err && !col_valid); // R7

  AST_ERR_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    !start |=> !cfg_err); // R7

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    col_last && !start |=> !col_valid); // R10
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .start_col (start_col),
  .mode_word (mode_word),
  .col_out   (col_out),
  .col_valid (col_valid),
  .col_last  (col_last),
  .cfg_err   (cfg_err),
  .mask_q    (len_mask_q),
  .ilv_q     (ilv_q)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  start_col = '0;
  logic [11:0] mode_word = '0;
  logic        terminate = 1'b0;
  logic [9:0]  col_out;
  logic        col_valid, col_last, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .mode_word(mode_word), .terminate(terminate), .col_out(col_out),
    .col_valid(col_valid), .col_last(col_last), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_col(input logic [9:0] sc, input int n,
                                         input int len, input bit ilv);
    logic [9:0] m, off, nn;
    m   = 10'(len - 1);
    nn  = 10'(n);
    off = ilv ? ((sc ^ nn) & m) : ((sc + nn) & m);
    return (sc & ~m) | off;
  endfunction

  // Caller is at a falling edge; terminate pulse given for full page at beat term_k.
  task automatic do_burst(input logic [9:0] sc, input logic [2:0] code,
                          input bit ilv, input int term_k, input string req);
    int len, nb;
    bit full, bad;
    full = 1'b0; bad = 1'b0; len = 1;
    case (code)
      3'd0: len = 1;
      3'd1: len = 2;
      3'd2: len = 4;
      3'd3: len = 8;
      3'd7: begin len = 1024; full = 1'b1; bad = ilv; end
      default: bad = 1'b1;
    endcase
    start     = 1'b1;
    start_col = sc;
    mode_word = {8'($urandom), ilv, code};
    terminate = full ? (term_k == 0) : 1'($urandom);
    @(negedge clk);
    start     = 1'b0;
    mode_word = 12'($urandom);
    if (bad) begin
      terminate = 1'b0;
      chk(cfg_err && !col_valid, "R7 error pulse", {col_valid, cfg_err}, 2'b01);
      @(negedge clk);
      chk(!cfg_err && !col_valid, "R7 no beat", {col_valid, cfg_err}, 2'b00);
      return;
    end
    chk(!cfg_err, "R7 legal code no error", cfg_err, 0);
    nb = full ? term_k + 1 : len;
    for (int n = 0; n < nb; n++) begin
      chk({col_valid, col_last, col_out} ===
          {1'b1, n == nb - 1, exp_col(sc, n, len, ilv)},
          req, {col_valid, col_last, col_out},
          {1'b1, n == nb - 1, exp_col(sc, n, len, ilv)});
      terminate = full ? (n + 1 == term_k) : 1'($urandom);
      if (n < nb - 1) @(negedge clk);
    end
    terminate = 1'b0;
    @(negedge clk);
    chk(!col_valid && !col_last, "R10 idle after last", {col_valid, col_last}, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk({col_valid, col_last, cfg_err, col_out} == 0, "R1 reset state",
        {col_valid, col_last, cfg_err, col_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({col_valid, col_last, cfg_err, col_out} == 0, "R1 after release",
        {col_valid, col_last, cfg_err, col_out}, 0);

    do_burst(10'h000, 3'd0, 1'b0, 0, "R2 R3 single beat");
    do_burst(10'h10D, 3'd1, 1'b0, 0, "R3 R4 length 2 sequential");
    do_burst(10'h10E, 3'd2, 1'b0, 0, "R4 length 4 sequential wrap");
    do_burst(10'h2F5, 3'd3, 1'b0, 0, "R4 length 8 sequential wrap");
    do_burst(10'h0A6, 3'd2, 1'b1, 0, "R5 length 4 interleaved");
    do_burst(10'h1FB, 3'd3, 1'b1, 0, "R5 length 8 interleaved");
    do_burst(10'h3FE, 3'd7, 1'b0, 5, "R6 full page row wrap");
    do_burst(10'h005, 3'd7, 1'b0, 1030, "R6 full page past one row");
    do_burst(10'h123, 3'd7, 1'b0, 0, "R6 terminate with start");
    do_burst(10'h044, 3'd7, 1'b1, 0, "R7 full page interleaved");
    do_burst(10'h044, 3'd5, 1'b0, 0, "R7 reserved code");
    do_burst(10'h3C1, 3'd3, 1'b0, 0, "R9 terminate ignored on fixed");

    // R8: abort an 8-beat burst after three beats.
    start = 1'b1; start_col = 10'h10A; mode_word = 12'h003;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 3; n++) begin
      chk(col_valid && col_out == exp_col(10'h10A, n, 8, 1'b0),
          "R8 beat before abort", col_out, exp_col(10'h10A, n, 8, 1'b0));
      if (n < 2) @(negedge clk);
    end
    do_burst(10'h3F5, 3'd2, 1'b1, 0, "R8 new burst after abort");

    for (int i = 0; i < 80; i++) begin
      int r;
      logic [2:0] code;
      r = int'($urandom % 10);
      if (r == 4)      code = 3'd7;
      else if (r == 5) code = 3'(4 + $urandom % 3);
      else             code = 3'($urandom % 4);
      do_burst(10'($urandom), code, 1'($urandom), int'($urandom % 40),
               "R3 R4 R5 R6 R9 random burst");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule